// File: doc/BRIEF.md
# Performance Event Counter Bank

A bank of ten 48-bit event counters behind a small register interface, intended to sit beside a processor core for performance monitoring. Counter 0 advances on every clock and counter 1 on every retired instruction. Counters 2 to 9 each follow one line of a 256-line event vector, picked by an 8-bit code held in one of two select registers. Every counter has its own count enable, its own interrupt enable, and two privilege filter bits: one for user level and one for kernel level. The core supplies the current level on `priv_kernel`.

Software reads and writes every counter and control word through a single-cycle write port. The read path is combinational and decodes the same address. An increment that takes a counter's top bit from 0 to 1 sets a sticky overflow status bit. Software clears that bit by writing a one to it. The interrupt line is raised when delivery is switched on, some flagged counter has its interrupt enable set, and the interrupt-active flag is clear. Raising the interrupt sets the active flag, so the line pulses for one cycle. Any write of the first control word clears the flag again.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter, enable, filter, select and status bit reads as zero, the delivery mode is off (0) and `irq_out` is low.
- R2: When enabled and allowed by the privilege filter, counter 0 adds one on every clock and counter 1 adds one on every clock with `insn_retired` high. The select registers have no effect on these two counters.
- R3: Counter k in 2..5 counts `event_vec[code]`, where code is bits 8(k-2)+7 : 8(k-2) of select register 12. Counter k in 6..9 uses bits 8(k-6)+7 : 8(k-6) of select register 13. Only bits 31:0 of either register are stored.
- R4: Control word 10 holds the count enables for counters 0..7 in bits 7:0 and for counters 8..9 in bits 33:32. A counter whose enable is clear holds its value.
- R5: Control word 11 holds the user-level enables in bits 7:0 (counters 0..7) and 33:32 (counters 8..9), and the kernel-level enables in bits 15:8 and 41:40. A counter advances only if the bit for the level on `priv_kernel` (1 = kernel) is set.
- R6: Counters are 48 bits and wrap to zero. Status bit k is set only when an increment takes bit 47 of counter k from 0 to 1. Writes and the wrap from all ones set nothing.
- R7: Status register 14 holds one sticky bit per counter in bits 9:0. Writing a one clears that bit. An overflow in the same cycle as its clear leaves the bit set.
- R8: Word 10 holds the interrupt enables in bits 15:8 (counters 0..7) and 45:44 (8..9), the mode in bits 17:16 (1 = deliver, other values = off) and the active flag in bit 20. `irq_out` is high exactly when the mode is 1, some status bit has its interrupt enable set, and the flag is clear. The flag is set on the edge where `irq_out` is high.
- R9: Any write of word 10 clears the active flag, whatever bit 20 holds, and this takes precedence over an interrupt raised in the same cycle.
- R10: A write of a counter at addresses 0..9 in the same cycle as its increment loads the written value. No increment is added.
- R11: Reads return counters zero-extended at addresses 0..9, the registers above at 10..14, and zero at address 15. A write to address 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for `reg_addr` |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| event_vec | input | 256 | Event pulses, one per event code |
| insn_retired | input | 1 | One instruction retired this cycle |
| priv_kernel | input | 1 | Current level: 1 kernel, 0 user |
| irq_out | output | 1 | Interrupt request |

## Verification
Two collisions are provoked on purpose. In the first, a counter write lands in the very cycle the counter is enabled to count, and the value read back after that edge must equal the written value exactly. In the second, a status clear-by-one lands in the cycle an increment carries a counter into bit 47, and the bit must stay set. A third collision, a write of control word 10 while an interrupt is pending, must leave the active flag clear and let `irq_out` rise again on the next cycle. A behavioural model in the bench tracks every register and judges `irq_out` and the read data on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int NUM_CTR    = 10;
  localparam int LO_CNT     = 8;
  localparam int HI_CNT     = NUM_CTR - LO_CNT;
  localparam int DATA_W     = 64;
  localparam int ADDR_W     = 4;
  localparam int EVT_CODE_W = 8;
  localparam int EVT_W      = 1 << EVT_CODE_W;
  localparam int SEL_W      = 4 * EVT_CODE_W;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL0  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_CTRL1  = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_SEL_LO = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_SEL_HI = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(14);

  // control word 0 field positions
  localparam int C0_EN_LO = 0;
  localparam int C0_IE_LO = 8;
  localparam int C0_MODE  = 16;
  localparam int C0_ACT   = 20;
  localparam int C0_EN_HI = 32;
  localparam int C0_IE_HI = 44;

  // control word 1 field positions
  localparam int C1_USR_LO = 0;
  localparam int C1_KRN_LO = 8;
  localparam int C1_USR_HI = 32;
  localparam int C1_KRN_HI = 40;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_FAST = 2'd1;

  typedef logic [NUM_CTR-1:0] ctr_mask_t;

  // collect a per-counter mask from its two split fields
  function automatic ctr_mask_t gather(input logic [DATA_W-1:0] r, input int lo, input int hi);
    ctr_mask_t m;
    m[LO_CNT-1:0]       = r[lo +: LO_CNT];
    m[NUM_CTR-1:LO_CNT] = r[hi +: HI_CNT];
    return m;
  endfunction

  // place a per-counter mask back into its two split fields
  function automatic logic [DATA_W-1:0] scatter(input ctr_mask_t m, input int lo, input int hi);
    logic [DATA_W-1:0] r;
    r = '0;
    r[lo +: LO_CNT] = m[LO_CNT-1:0];
    r[hi +: HI_CNT] = m[NUM_CTR-1:LO_CNT];
    return r;
  endfunction

  // event code of a selectable counter
  function automatic logic [EVT_CODE_W-1:0] code_of(input logic [SEL_W-1:0] sel_lo,
                                                    input logic [SEL_W-1:0] sel_hi,
                                                    input int idx);
    if (idx < 2)      return '0;
    else if (idx < 6) return sel_lo[(idx-2)*EVT_CODE_W +: EVT_CODE_W];
    else              return sel_hi[(idx-6)*EVT_CODE_W +: EVT_CODE_W];
  endfunction

endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         inc_en,
  output logic [W-1:0] count,
  output logic         ovf_pulse
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  assign cnt_inc   = cnt_q + W'(1);
  // top bit goes 0 -> 1 through an increment that is not overridden by a write
  assign ovf_pulse = inc_en & ~wr_en & ~cnt_q[W-1] & cnt_inc[W-1];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_en)  cnt_q <= wr_val;
    else if (inc_en) cnt_q <= cnt_inc;
  end

endmodule

// File: rtl/pmc_irq_ctrl.sv
module pmc_irq_ctrl
  import pmc_pkg::*;
#(
  parameter int N = NUM_CTR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_wr,
  input  logic [1:0]   mode_in,
  input  logic         w1c_en,
  input  logic [N-1:0] w1c_mask,
  input  logic [N-1:0] ovf_set,
  input  logic [N-1:0] irq_en,
  output logic [1:0]   mode_q,
  output logic         active_q,
  output logic [N-1:0] status_q,
  output logic         irq_req
);

  logic [N-1:0] clr_mask;

  assign clr_mask = w1c_en ? w1c_mask : '0;
  assign irq_req  = (mode_q == MODE_FAST) && (|(status_q & irq_en)) && !active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_OFF;
      active_q <= 1'b0;
      status_q <= '0;
    end else begin
      if (mode_wr) mode_q <= mode_in;
      if (mode_wr)      active_q <= 1'b0;
      else if (irq_req) active_q <= 1'b1;
      // a fresh overflow wins over a clear in the same cycle
      status_q <= (status_q & ~clr_mask) | ovf_set;
    end
  end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pmc_pkg::*;
#(
  parameter int CTR_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  event_vec,
  input  logic              insn_retired,
  input  logic              priv_kernel,
  output logic              irq_out
);

  // named internal events
  logic ctrl0_wr, ctrl1_wr, sel_lo_wr, sel_hi_wr, status_w1c;
  ctr_mask_t cnt_en, irq_en, user_en, kern_en;
  ctr_mask_t ctr_wr, inc, evt_hit, ovf_set, ovf_status;
  logic [SEL_W-1:0] sel_lo, sel_hi;
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_val;
  logic [CTR_W-1:0] wr_val;
  logic [1:0] irq_mode;
  logic irq_active;
  logic unused_wdata_hi;

  assign ctrl0_wr   = reg_wr && (reg_addr == A_CTRL0);
  assign ctrl1_wr   = reg_wr && (reg_addr == A_CTRL1);
  assign sel_lo_wr  = reg_wr && (reg_addr == A_SEL_LO);
  assign sel_hi_wr  = reg_wr && (reg_addr == A_SEL_HI);
  assign status_w1c = reg_wr && (reg_addr == A_STATUS);
  assign wr_val     = reg_wdata[CTR_W-1:0];
  assign unused_wdata_hi = ^(reg_wdata >> CTR_W);

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_en  <= '0;
      irq_en  <= '0;
      user_en <= '0;
      kern_en <= '0;
      sel_lo  <= '0;
      sel_hi  <= '0;
    end else begin
      if (ctrl0_wr) begin
        cnt_en <= gather(reg_wdata, C0_EN_LO, C0_EN_HI);
        irq_en <= gather(reg_wdata, C0_IE_LO, C0_IE_HI);
      end
      if (ctrl1_wr) begin
        user_en <= gather(reg_wdata, C1_USR_LO, C1_USR_HI);
        kern_en <= gather(reg_wdata, C1_KRN_LO, C1_KRN_HI);
      end
      if (sel_lo_wr) sel_lo <= reg_wdata[SEL_W-1:0];
      if (sel_hi_wr) sel_hi <= reg_wdata[SEL_W-1:0];
    end
  end

  // per-counter event source, filter and storage
  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    if (i == 0) begin : g_cyc
      assign evt_hit[i] = 1'b1;
    end else if (i == 1) begin : g_ins
      assign evt_hit[i] = insn_retired;
    end else begin : g_sel
      assign evt_hit[i] = event_vec[code_of(sel_lo, sel_hi, i)];
    end

    assign ctr_wr[i] = reg_wr && (reg_addr == ADDR_W'(i));
    assign inc[i]    = cnt_en[i] && evt_hit[i] && (priv_kernel ? kern_en[i] : user_en[i]);

    pmc_counter #(.W(CTR_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ctr_wr[i]),
      .wr_val    (wr_val),
      .inc_en    (inc[i]),
      .count     (ctr_val[i]),
      .ovf_pulse (ovf_set[i])
    );
  end

  pmc_irq_ctrl #(.N(NUM_CTR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (ctrl0_wr),
    .mode_in  (reg_wdata[C0_MODE +: 2]),
    .w1c_en   (status_w1c),
    .w1c_mask (reg_wdata[NUM_CTR-1:0]),
    .ovf_set  (ovf_set),
    .irq_en   (irq_en),
    .mode_q   (irq_mode),
    .active_q (irq_active),
    .status_q (ovf_status),
    .irq_req  (irq_out)
  );

  // read path
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == ADDR_W'(i)) reg_rdata = DATA_W'(ctr_val[i]);
    end
    case (reg_addr)
      A_CTRL0:  reg_rdata = scatter(cnt_en, C0_EN_LO, C0_EN_HI)
                          | scatter(irq_en, C0_IE_LO, C0_IE_HI)
                          | (DATA_W'(irq_mode) << C0_MODE)
                          | (DATA_W'(irq_active) << C0_ACT);
      A_CTRL1:  reg_rdata = scatter(user_en, C1_USR_LO, C1_USR_HI)
                          | scatter(kern_en, C1_KRN_LO, C1_KRN_HI);
      A_SEL_LO: reg_rdata = DATA_W'(sel_lo);
      A_SEL_HI: reg_rdata = DATA_W'(sel_hi);
      A_STATUS: reg_rdata = DATA_W'(ovf_status);
      default:  ;
    endcase
  end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int N = 10,
  parameter int W = 48
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctrl0_wr,
  input logic                status_w1c,
  input logic                irq_out,
  input logic                irq_active,
  input logic [1:0]          irq_mode,
  input logic [N-1:0]        ovf_set,
  input logic [N-1:0]        ovf_status,
  input logic [N-1:0]        ctr_wr,
  input logic [N-1:0][W-1:0] ctr_val,
  input logic [W-1:0]        wr_val
);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_w1c |=> ((ovf_status & $past(ovf_status)) == $past(ovf_status)));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_set) |=> ((ovf_status & $past(ovf_set)) == $past(ovf_set)));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl0_wr |=> !irq_active);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irq_mode == 2'd1) && !irq_active && (ovf_status != '0));

  // R8
  irq_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !ctrl0_wr) |=> irq_active);

  for (genvar i = 0; i < N; i++) begin : g_wr
    // R10
    wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_wr[i] |=> (ctr_val[i] == $past(wr_val)));
  end

endmodule

bind perf_counter_bank pmc_checker #(.N(pmc_pkg::NUM_CTR), .W(CTR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl0_wr   (ctrl0_wr),
  .status_w1c (status_w1c),
  .irq_out    (irq_out),
  .irq_active (irq_active),
  .irq_mode   (irq_mode),
  .ovf_set    (ovf_set),
  .ovf_status (ovf_status),
  .ctr_wr     (ctr_wr),
  .ctr_val    (ctr_val),
  .wr_val     (wr_val)
);

// File: tb/test_perf_counter_bank.sv
module test_perf_counter_bank;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr;
  logic [3:0]   reg_addr;
  logic [63:0]  reg_wdata;
  logic [63:0]  reg_rdata;
  logic [255:0] event_vec;
  logic         insn_retired;
  logic         priv_kernel;
  logic         irq_out;

  always #10 clk = ~clk; // 50 MHz

  perf_counter_bank i_perf_counter_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .event_vec    (event_vec),
    .insn_retired (insn_retired),
    .priv_kernel  (priv_kernel),
    .irq_out      (irq_out)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  localparam longint unsigned MASK48 = 64'h0000_FFFF_FFFF_FFFF;
  longint unsigned m_ctr[10];
  logic [9:0]  m_en, m_ie, m_ue, m_ke, m_st;
  logic [1:0]  m_md;
  bit          m_act;
  logic [31:0] m_sl, m_sh;

  localparam logic [255:0] EV_ALL = {256{1'b1}};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_read(input int a);
    logic [63:0] r;
    r = '0;
    if (a < 10) r = m_ctr[a];
    else if (a == 10) begin
      r[7:0] = m_en[7:0]; r[15:8] = m_ie[7:0]; r[17:16] = m_md; r[20] = m_act;
      r[33:32] = m_en[9:8]; r[45:44] = m_ie[9:8];
    end else if (a == 11) begin
      r[7:0] = m_ue[7:0]; r[15:8] = m_ke[7:0];
      r[33:32] = m_ue[9:8]; r[41:40] = m_ke[9:8];
    end else if (a == 12) r[31:0] = m_sl;
    else if (a == 13) r[31:0] = m_sh;
    else if (a == 14) r[9:0] = m_st;
    return r;
  endfunction

  function automatic string tag_of(input int a);
    if (a < 2)       return "R2 read";
    else if (a < 10) return "R3 read";
    else if (a == 10) return "R4 read";
    else if (a == 11) return "R5 read";
    else if (a < 14) return "R3 select read";
    else if (a == 14) return "R7 read";
    else             return "R11 read";
  endfunction

  // one clock: drive, compare against the model, advance the model
  task automatic cyc(input bit wr, input int a, input logic [63:0] wd,
                     input logic [255:0] ev, input bit ins, input bit kern);
    logic [9:0] setv;
    bit irq_now;
    @(negedge clk);
    reg_wr = wr; reg_addr = 4'(a); reg_wdata = wd;
    event_vec = ev; insn_retired = ins; priv_kernel = kern;
    #1;
    irq_now = (m_md == 2'd1) && (|(m_st & m_ie)) && !m_act;
    check("R8 irq", 64'(irq_out), 64'(irq_now));
    check(tag_of(a), reg_rdata, m_read(a));
    setv = '0;
    for (int i = 0; i < 10; i++) begin
      bit e;
      bit p;
      logic [7:0] c;
      longint unsigned o;
      c = '0;
      if (i == 0) e = 1'b1;
      else if (i == 1) e = ins;
      else begin
        if (i < 6) c = m_sl[(i-2)*8 +: 8];
        else       c = m_sh[(i-6)*8 +: 8];
        e = ev[c];
      end
      p = kern ? m_ke[i] : m_ue[i];
      o = m_ctr[i];
      if (wr && a == i) m_ctr[i] = wd & MASK48;
      else if (m_en[i] && p && e) begin
        m_ctr[i] = (o + 1) & MASK48;
        if (!o[47] && m_ctr[i][47]) setv[i] = 1'b1;
      end
    end
    if (wr && a == 14) m_st = m_st & ~wd[9:0];
    m_st = m_st | setv;
    if (wr && a == 10) m_act = 1'b0;
    else if (irq_now) m_act = 1'b1;
    if (wr && a == 10) begin
      m_en = {wd[33:32], wd[7:0]}; m_ie = {wd[45:44], wd[15:8]}; m_md = wd[17:16];
    end
    if (wr && a == 11) begin
      m_ue = {wd[33:32], wd[7:0]}; m_ke = {wd[41:40], wd[15:8]};
    end
    if (wr && a == 12) m_sl = wd[31:0];
    if (wr && a == 13) m_sh = wd[31:0];
    @(posedge clk);
  endtask

  // check read data just after the edge of the last cycle
  task automatic post(input string tag, input logic [63:0] exp);
    #1;
    check(tag, reg_rdata, exp);
  endtask

  function automatic logic [255:0] rnd_ev();
    logic [255:0] v;
    for (int j = 0; j < 8; j++) v[j*32 +: 32] = $urandom();
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    event_vec = '0; insn_retired = 1'b0; priv_kernel = 1'b0;
    for (int i = 0; i < 10; i++) m_ctr[i] = 0;
    m_en = '0; m_ie = '0; m_ue = '0; m_ke = '0; m_st = '0; m_md = '0; m_act = 0;
    m_sl = '0; m_sh = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on every address
    for (int a = 0; a < 16; a++) cyc(0, a, '0, '0, 0, 0);
    #1 check("R1 irq after reset", 64'(irq_out), 64'd0);

    // R2: cycle and instruction counters, all privileges open
    cyc(1, 11, 64'h0000_0303_0000_FFFF, '0, 0, 1);
    cyc(1, 10, 64'h0000_0000_0000_0003, '0, 0, 1);
    for (int k = 0; k < 20; k++) cyc(0, k % 2, '0, rnd_ev(), (k % 3) == 0, k[0]);

    // R3: select codes, all counters enabled
    cyc(1, 12, 64'h0000_0000_00FF_8005, '0, 0, 1);
    cyc(1, 13, 64'h0000_0000_1312_1110, '0, 0, 1);
    cyc(1, 10, 64'h0000_0003_0000_00FF, '0, 0, 1);
    for (int k = 0; k < 40; k++) cyc(0, 2 + (k % 12), '0, rnd_ev(), k[1], k[0]);

    // R5: privilege filter split
    cyc(1, 11, 64'h0000_0201_0000_0FF0, '0, 0, 1);
    for (int k = 0; k < 30; k++) cyc(0, k % 10, '0, rnd_ev(), k[0], k[2]);
    cyc(1, 0, 64'h55, '0, 0, 0);
    cyc(0, 0, '0, '0, 0, 0);
    post("R5 user level blocks counter 0", 64'h55);
    cyc(0, 0, '0, '0, 0, 1);
    post("R5 kernel level lets counter 0 count", 64'h56);

    // R10: write meets increment
    cyc(1, 0, 64'h1234, '0, 0, 1);
    post("R10 write wins over increment", 64'h1234);
    cyc(0, 0, '0, '0, 0, 1);
    post("R2 counter 0 resumes", 64'h1235);

    // R6: wrap without overflow
    cyc(1, 11, 64'h0000_0303_0000_FFFF, '0, 0, 1);
    cyc(1, 14, 64'h3FF, '0, 0, 1);
    cyc(1, 2, 64'h0000_FFFF_FFFF_FFFF, '0, 0, 1);
    post("R6 counter loaded", 64'h0000_FFFF_FFFF_FFFF);
    cyc(0, 2, '0, EV_ALL, 0, 1);
    post("R6 wrap to zero", 64'h0);
    cyc(0, 14, '0, '0, 0, 1);
    post("R6 wrap sets no status", 64'h0);

    // R6 and R8: overflow raises status and interrupt
    cyc(1, 10, 64'h0000_2003_0001_08FF, '0, 0, 1);
    cyc(1, 3, 64'h0000_7FFF_FFFF_FFFF, '0, 0, 1);
    cyc(0, 14, '0, EV_ALL, 0, 1);
    post("R6 overflow status", 64'h8);
    cyc(0, 10, '0, '0, 0, 1);
    post("R8 active flag set", 64'h0000_2003_0011_08FF);

    // R9: control write clears active, interrupt rises again
    cyc(1, 10, 64'h0000_2003_0011_08FF, '0, 0, 1);
    post("R9 active cleared", 64'h0000_2003_0001_08FF);
    check("R9 irq re-raised", 64'(irq_out), 64'd1);
    cyc(0, 10, '0, '0, 0, 1);

    // R7: clear by one, then set wins over clear
    cyc(1, 14, 64'h8, '0, 0, 1);
    post("R7 clear by one", 64'h0);
    cyc(1, 9, 64'h0000_7FFF_FFFF_FFFF, '0, 0, 1);
    cyc(1, 14, 64'h200, EV_ALL, 0, 1);
    post("R7 set wins over clear", 64'h200);
    cyc(0, 14, '0, '0, 0, 1);
    post("R7 sticky", 64'h200);
    cyc(1, 10, 64'h0000_2003_0001_08FF, '0, 0, 1);

    // R11: unmapped address
    cyc(1, 15, {64{1'b1}}, '0, 0, 1);
    post("R11 unmapped reads zero", 64'h0);
    for (int a = 0; a < 16; a++) cyc(0, a, '0, '0, 0, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule